// File: doc/BRIEF.md
# Two-Stage High/Low Count Clock Divider

This block derives a slower clock from its input clock. Each of its two divider stages holds its output high for a programmed number of input cycles and then low for a second programmed number. The output period is the sum of the two counts, and the duty cycle can be set to any whole number of input cycles. A half-duty mode replaces the stage's own high/low split with an even split of the same period. In that mode the extra cycle of an odd period goes to the high phase.

The second stage advances only once for each period of the first stage. Selecting the chained path therefore divides by the product of the two stage periods, which reaches far lower frequencies than a single stage can. When the chained path is not selected, the block output comes from the first stage alone. A one-cycle period-start pulse marks the first input cycle of every output period. Both outputs are registered.

Top module: `clkdiv_hilo_top`

## Requirements
- R1: The period of a stage is D = H + L input cycles, where H is its high count and L is its low count. The output repeats with exactly this period, so D ranges from 2 to 512.
- R2: Each count field is 8 bits wide and encodes the value minus one. Field value f means f+1 cycles, so 0 means 1 and 255 means 256.
- R3: With `half_duty` = 0, the output is high for the first H cycles of each period and low for the remaining L cycles.
- R4: With `half_duty` = 1, the high phase lasts ceil(D/2) cycles and the low phase lasts floor(D/2) cycles. H and L only set the period.
- R5: After the first rising edge with `rst` low (edge e0), `clk_out` is still 0. From edge e1 onward, the output sampled after edge ej (j ≥ 1) is high exactly when ((j-1) mod D) < high phase. `period_start` is 1 exactly when (j-1) mod D = 0, and is never 1 while `clk_out` is 0.
- R6: A change of the count fields or of `half_duty` has no effect on the period in progress. The new values are taken at the start of the next period.
- R7: With `chain_en` = 1, stage B advances once per stage A period. Stage A has period DA; stage B has period DB and high phase HB. After edge ej (j ≥ 2), with n = floor((j-2)/DA), `clk_out` is high exactly when (n mod DB) < HB. `period_start` is 1 exactly when (j-2) mod DA = 0 and n mod DB = 0. The overall period is DA·DB.
- R8: While `rst` is high at a rising edge, both outputs become 0 after that edge, whatever state the block was in.
- R9: With `chain_en` = 0, `clk_out` and `period_start` depend only on the stage A fields. The stage B fields have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_a_m1 | input | 8 | Stage A high count minus one |
| lo_a_m1 | input | 8 | Stage A low count minus one |
| hi_b_m1 | input | 8 | Stage B high count minus one |
| lo_b_m1 | input | 8 | Stage B low count minus one |
| half_duty | input | 1 | 1 selects the even split for both stages |
| chain_en | input | 1 | 1 routes stage B, fed by stage A, to the outputs; 0 routes stage A |
| clk_out | output | 1 | Divided clock, registered |
| period_start | output | 1 | One-cycle pulse in the first cycle of each output period |

## Verification
For a single stage, every result is due one edge after the stage register that produces it. The output sampled after edge ej therefore reflects stage position j-1. The bench counts edges from reset release and samples each output at the falling edge following ej.

For the chained path, stage B steps on the edge after stage A's start pulse and the output register adds one more edge. Expected values there are built from position j-2.

For a count change made partway through a period, the expected waveform keeps the old shape until the edge that begins the next period. The new shape is checked from that edge on.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // width of one count field (value minus one)
  localparam int unsigned DIV_CNT_W = 8;
  // width that holds a full period (up to 2 * 2**DIV_CNT_W)
  localparam int unsigned DIV_SUM_W = DIV_CNT_W + 2;
  // number of chained stages
  localparam int unsigned DIV_STAGES = 2;

  typedef logic [DIV_CNT_W-1:0] cnt_t;
  typedef logic [DIV_SUM_W-1:0] span_t;

  typedef struct packed {
    span_t high_len;
    span_t period_len;
  } shape_t;
endpackage

// File: rtl/clkdiv_shape.sv
module clkdiv_shape
  import clkdiv_pkg::*;
(
  input  cnt_t   hi_m1,
  input  cnt_t   lo_m1,
  input  logic   half_en,
  output shape_t shape
);
  span_t period_w;
  span_t half_high_w;
  span_t own_high_w;

  always_comb begin
    period_w    = span_t'(hi_m1) + span_t'(lo_m1) + span_t'(2);
    half_high_w = (period_w + span_t'(1)) >> 1;
    own_high_w  = span_t'(hi_m1) + span_t'(1);
    shape.period_len = period_w;
    shape.high_len   = half_en ? half_high_w : own_high_w;
  end
endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step_en,
  input  shape_t shape,
  output logic   div_q,
  output logic   start_q
);
  logic   running;
  span_t  pos;
  shape_t cur;
  span_t  next_pos;
  logic   wrap;

  always_comb begin
    next_pos = pos + span_t'(1);
    wrap     = !running || (pos == cur.period_len - span_t'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pos     <= '0;
      cur     <= '0;
      div_q   <= 1'b0;
      start_q <= 1'b0;
    end else if (step_en) begin
      start_q <= wrap;
      if (wrap) begin
        running <= 1'b1;
        pos     <= '0;
        cur     <= shape;
        div_q   <= 1'b1;
      end else begin
        pos     <= next_pos;
        div_q   <= (next_pos < cur.high_len);
      end
    end else begin
      start_q <= 1'b0;
    end
  end

  AST_START_MEANS_HIGH: assert property (@(posedge clk) disable iff (rst)
    start_q |-> div_q); // R5
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    running |-> (pos < cur.period_len)); // R1
  AST_FALL_POINT: assert property (@(posedge clk) disable iff (rst)
    (running && $fell(div_q)) |-> (pos == cur.high_len)); // R3
  AST_SHAPE_HELD: assert property (@(posedge clk) disable iff (rst)
    (step_en && !wrap) |=> $stable(cur)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(div_q) && !start_q)); // R7
endmodule

// File: rtl/clkdiv_hilo_top.sv
module clkdiv_hilo_top
  import clkdiv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_CNT_W-1:0] hi_a_m1,
  input  logic [DIV_CNT_W-1:0] lo_a_m1,
  input  logic [DIV_CNT_W-1:0] hi_b_m1,
  input  logic [DIV_CNT_W-1:0] lo_b_m1,
  input  logic                 half_duty,
  input  logic                 chain_en,
  output logic                 clk_out,
  output logic                 period_start
);
  localparam int unsigned LAST = DIV_STAGES - 1;

  cnt_t   hi_sel [DIV_STAGES];
  cnt_t   lo_sel [DIV_STAGES];
  shape_t shp    [DIV_STAGES];
  logic   en     [DIV_STAGES];
  logic   q      [DIV_STAGES];
  logic   st     [DIV_STAGES];

  always_comb begin
    hi_sel[0] = hi_a_m1;
    lo_sel[0] = lo_a_m1;
    hi_sel[1] = hi_b_m1;
    lo_sel[1] = lo_b_m1;
  end

  for (genvar i = 0; i < DIV_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign en[i] = 1'b1;
    end else begin : g_chained
      assign en[i] = st[i-1];
    end

    clkdiv_shape u_shape (
      .hi_m1   (hi_sel[i]),
      .lo_m1   (lo_sel[i]),
      .half_en (half_duty),
      .shape   (shp[i])
    );

    clkdiv_stage u_stage (
      .clk     (clk),
      .rst     (rst),
      .step_en (en[i]),
      .shape   (shp[i]),
      .div_q   (q[i]),
      .start_q (st[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out      <= 1'b0;
      period_start <= 1'b0;
    end else begin
      clk_out      <= chain_en ? q[LAST] : q[0];
      period_start <= chain_en ? st[LAST] : st[0];
    end
  end

  AST_START_WITH_HIGH: assert property (@(posedge clk) disable iff (rst)
    period_start |-> clk_out); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (period_start && !$past(chain_en) && !chain_en) |=> !period_start); // R1
endmodule

// File: tb/clkdiv_hilo_top_tb_top.sv
module clkdiv_hilo_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] hi_a_m1 = '0, lo_a_m1 = '0, hi_b_m1 = '0, lo_b_m1 = '0;
  logic half_duty = 1'b0, chain_en = 1'b0;
  logic clk_out, period_start;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clkdiv_hilo_top dut_i (
    .clk(clk), .rst(rst),
    .hi_a_m1(hi_a_m1), .lo_a_m1(lo_a_m1),
    .hi_b_m1(hi_b_m1), .lo_b_m1(lo_b_m1),
    .half_duty(half_duty), .chain_en(chain_en),
    .clk_out(clk_out), .period_start(period_start)
  );

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
    logic       half;
    int         high;
    int         period;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   8'd0,   1'b0, 1,   2},
    '{8'd2,   8'd4,   1'b0, 3,   8},
    '{8'd4,   8'd1,   1'b0, 5,   7},
    '{8'd4,   8'd1,   1'b1, 4,   7},
    '{8'd0,   8'd5,   1'b1, 4,   7},
    '{8'd1,   8'd1,   1'b1, 2,   4},
    '{8'd255, 8'd0,   1'b0, 256, 257},
    '{8'd255, 8'd255, 1'b1, 256, 512},
    '{8'd0,   8'd255, 1'b0, 1,   257}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // hold reset two edges, then release at a falling edge; returns after e0
  task automatic restart();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int errs_q, errs_s, first_bad, exp_v;
    // reset state (R8)
    @(negedge clk); @(negedge clk);
    chk(clk_out == 1'b0 && period_start == 1'b0, "R8 reset state", clk_out, 0);

    // table walk: single stage, stage B fields set to something else (R9)
    for (int v = 0; v < NV; v++) begin
      hi_a_m1 = VECS[v].hi; lo_a_m1 = VECS[v].lo; half_duty = VECS[v].half;
      hi_b_m1 = 8'd3; lo_b_m1 = 8'd6; chain_en = 1'b0;
      restart();
      chk(clk_out == 1'b0, "R5 not high after e0", clk_out, 0);
      errs_q = 0; errs_s = 0; first_bad = -1;
      for (int j = 1; j <= 2 * VECS[v].period; j++) begin
        @(negedge clk);
        exp_v = (((j - 1) % VECS[v].period) < VECS[v].high) ? 1 : 0;
        if (clk_out !== exp_v[0]) begin errs_q++; if (first_bad < 0) first_bad = j; end
        if (period_start !== (((j - 1) % VECS[v].period) == 0)) errs_s++;
      end
      chk(errs_q == 0, VECS[v].half ? "R4 R1 R2 R9 half shape" : "R3 R1 R2 R9 own shape",
          first_bad, -1);
      chk(errs_s == 0, "R5 period_start", errs_s, 0);
    end

    // count change mid-period (R6): 2+2 -> 1+5
    hi_a_m1 = 8'd1; lo_a_m1 = 8'd1; half_duty = 1'b0; chain_en = 1'b0;
    restart();
    errs_q = 0; errs_s = 0;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      if (j <= 4) exp_v = (((j - 1) % 4) < 2) ? 1 : 0;
      else        exp_v = (((j - 5) % 6) < 1) ? 1 : 0;
      if (clk_out !== exp_v[0]) errs_q++;
      if (period_start !== (j == 1 || j == 5 || j == 11)) errs_s++;
      if (j == 2) begin hi_a_m1 = 8'd0; lo_a_m1 = 8'd4; end
    end
    chk(errs_q == 0, "R6 clk_out across change", errs_q, 0);
    chk(errs_s == 0, "R6 period_start across change", errs_s, 0);

    // half_duty change mid-period (R6): 5+2 own -> half
    hi_a_m1 = 8'd4; lo_a_m1 = 8'd1; half_duty = 1'b0;
    restart();
    errs_q = 0;
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      if (j <= 7) exp_v = ((j - 1) < 5) ? 1 : 0;
      else        exp_v = ((j - 8) < 4) ? 1 : 0;
      if (clk_out !== exp_v[0]) errs_q++;
      if (j == 1) half_duty = 1'b1;
    end
    chk(errs_q == 0, "R6 mode change waits for period", errs_q, 0);

    // cascade runs (R7)
    for (int c = 0; c < 2; c++) begin
      int da, db, hb;
      if (c == 0) begin
        hi_a_m1 = 8'd1; lo_a_m1 = 8'd0; hi_b_m1 = 8'd0; lo_b_m1 = 8'd0;
        half_duty = 1'b0; da = 3; db = 2; hb = 1;
      end else begin
        hi_a_m1 = 8'd0; lo_a_m1 = 8'd0; hi_b_m1 = 8'd2; lo_b_m1 = 8'd1;
        half_duty = 1'b1; da = 2; db = 5; hb = 3;
      end
      chain_en = 1'b1;
      restart();
      errs_q = 0; errs_s = 0;
      for (int j = 1; j <= 3 * da * db + 2; j++) begin
        int n;
        bit es;
        @(negedge clk);
        n = (j >= 2) ? (j - 2) / da : 0;
        exp_v = (j >= 2 && (n % db) < hb) ? 1 : 0;
        es = (j >= 2) && ((j - 2) % da == 0) && (n % db == 0);
        if (clk_out !== exp_v[0]) errs_q++;
        if (period_start !== es) errs_s++;
      end
      chk(errs_q == 0, "R7 chained clk_out", errs_q, 0);
      chk(errs_s == 0, "R7 chained period_start", errs_s, 0);
    end

    // reset while output is high (R8)
    chain_en = 1'b0; hi_a_m1 = 8'd9; lo_a_m1 = 8'd9; half_duty = 1'b0;
    restart();
    @(negedge clk); @(negedge clk);
    chk(clk_out == 1'b1, "R8 high before reset", clk_out, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(clk_out == 1'b0 && period_start == 1'b0, "R8 reset clears", clk_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_out == 1'b0, "R5 restart latency", clk_out, 0);
    @(negedge clk);
    chk(clk_out == 1'b1 && period_start == 1'b1, "R5 restart first period", clk_out, 1);

    finish_run();
  end
endmodule